// File: doc/BRIEF.md
# Network Controller Command, Interrupt and Transmit-Launch Register Block

This block is the register slave that sits behind a 256-byte I/O window of an Ethernet controller. A bus protocol adapter presents single-beat accesses of one, two or four bytes. The block answers the read data one cycle later. It holds the station address, the multicast filter bytes, the command byte, the interrupt mask and status pair, four transmit descriptor slots (a start address and a status word each), and the basic-mode PHY control and status words. Every other location inside the register span is plain byte storage.

Software starts a transmission by writing a descriptor's status word. The block then pulses a launch request for one cycle toward an external frame fetcher, carrying the slot number, the slot's start address and the byte count. It also marks the descriptor as owned and complete, and it raises the transmit-done interrupt cause. The fetched bytes come back through a streaming port. The block forwards them toward the wire and appends a CRC-32 trailer after the last byte. The interrupt request output is active while any unmasked cause is pending. Reading the status word hands the pending causes to software and clears them in the same access.

Top module: `nic_ctl_regs`

## Requirements
- R1: After reset the block holds these values. The station address occupies bytes 0x00..0x05, with byte 0x00 equal to STATION_ADDR[47:40] and following bytes taken from successively lower octets. The command byte at 0x37 reads 0x01. The 32-bit word at 0x40 reads 0x63000000. The byte at 0x58 reads 0x90. The half-word at 0x62 reads 0x2000 and the half-word at 0x64 reads 0x2025. Interrupt mask and status are zero, and intr_req, tx_go and wire_valid are low.
- R2: A read of the half-word at 0x3E returns the interrupt status, and the status becomes zero in the same cycle. A cause arriving on evt_set in that same cycle is kept, so a following read returns it.
- R3: intr_req is high exactly when the half-word mask at 0x3C and the interrupt status share a set bit.
- R4: A write to byte 0x37 sets receiver enable with data bit 3 and transmitter enable with data bit 2. These bits are sticky and read back at 0x37 bits 3 and 2, and they drive rx_enabled and tx_enabled.
- R5: A write to byte 0x37 with data bit 4 set returns every register to its R1 value. This includes the interrupt status and the enables.
- R6: A write to byte 0x37 with any data bit outside bits 4..2 set pulses cmd_bad high for the following cycle. Otherwise cmd_bad stays low.
- R7: A write whose address is 0x10, 0x14, 0x18 or 0x1C (slot n = address bits 3:2) makes tx_go high for exactly the next cycle. In that cycle tx_slot = n, tx_addr is the 32-bit word at 0x20+4n, and tx_len = write data bits 11:0.
- R8: After such a launch, the status word of slot n reads the written data with bits 13 and 15 forced to one, and interrupt status bit 2 is set.
- R9: Bit 9 of the half-word at 0x62 always stores zero, whatever the width of the write.
- R10: All other locations below the span are byte-addressable storage. Access size code 0/1/2 means 1/2/4 bytes. Bytes are little-endian: byte address a+k sits on data bits 8k+7..8k. Read data appears on bus_rdata one cycle after the access and holds until the next read.
- R11: Bytes at or above the register span end (0x81 by default) read zero, and writes to them are ignored.
- R12: A frame streamed in on fr_* leaves on wire_* one cycle later, followed by 4 CRC bytes, least significant first. The CRC uses the reflected polynomial 0xEDB88320, starts at all ones and is inverted at the end. wire_last marks only the final CRC byte, and fr_ready is low while the trailer is sent.
- R13: Writes to bytes 0x3E and 0x3F are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the access |
| bus_size | input | 2 | 0 = byte, 1 = half-word, 2 = word |
| bus_wdata | input | 32 | Write data, little-endian lanes |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| evt_set | input | 16 | Interrupt causes to set from other units |
| intr_req | output | 1 | Interrupt request |
| rx_enabled | output | 1 | Receiver enable from the command byte |
| tx_enabled | output | 1 | Transmitter enable from the command byte |
| cmd_bad | output | 1 | Pulse: command write carried invalid bits |
| tx_go | output | 1 | Transmit launch pulse |
| tx_slot | output | 2 | Launched descriptor slot |
| tx_addr | output | 32 | Start address of the launched slot |
| tx_len | output | 12 | Byte count of the launched frame |
| fr_valid | input | 1 | Fetched frame byte valid |
| fr_ready | output | 1 | Block accepts a frame byte |
| fr_data | input | 8 | Fetched frame byte |
| fr_last | input | 1 | Last byte of the fetched frame |
| wire_valid | output | 1 | Outgoing byte valid |
| wire_data | output | 8 | Outgoing byte |
| wire_last | output | 1 | Final byte of the frame including CRC |

## Verification
The bench targets five corner cases and the symptom each bug would show:
- A new cause arriving during the clearing read of the interrupt status. A design that lets the clear win drops that cause, and the next read comes back zero.
- Bit 9 of the PHY control word, written both as a half-word and as a lone upper byte. A design that masks only aligned half-word writes stores the bit through the byte path.
- Sub-word writes into a word, and a word read that straddles the span end. Wrong lane steering shows up as shuffled bytes, and a missing range check returns stale data instead of zero.
- The CRC trailer, checked against the standard check value of the nine ASCII digits and a second short frame. A design that emits the CRC most significant byte first, skips the final inversion or marks the wrong byte as last produces a different four-byte tail.
- The full-reset command. A partial implementation leaves the enables, the mask or scratch storage unchanged.

// File: rtl/nic_ctl_pkg.sv
package nic_ctl_pkg;

  localparam logic [7:0] OFS_TSD0 = 8'h10;
  localparam logic [7:0] OFS_TSA0 = 8'h20;
  localparam logic [7:0] OFS_CMD  = 8'h37;
  localparam logic [7:0] OFS_IMR  = 8'h3C;
  localparam logic [7:0] OFS_ISR  = 8'h3E;
  localparam logic [7:0] OFS_TCFG = 8'h40;
  localparam logic [7:0] OFS_MED  = 8'h58;
  localparam logic [7:0] OFS_PCTL = 8'h62;
  localparam logic [7:0] OFS_PSTS = 8'h64;

  localparam logic [7:0]  CMD_RESET_VAL = 8'h01;
  localparam logic [7:0]  CMD_SET_MASK  = 8'h0C;
  localparam logic [7:0]  CMD_OK_MASK   = 8'h1C;
  localparam int          CMD_RST_BIT   = 4;
  localparam logic [15:0] ISR_TX_DONE   = 16'h0004;
  localparam logic [7:0]  OWN_DONE_HI   = 8'hA0;
  localparam int          PCTL_HI_CLR   = 1;
  localparam logic [31:0] CRC_POLY      = 32'hEDB88320;

  typedef enum logic [0:0] {ST_PASS, ST_TRAIL} crc_st_t;

  function automatic logic [7:0] reset_byte(input int unsigned idx,
                                            input logic [47:0] station);
    logic [7:0] v;
    v = 8'h00;
    if (idx < 6) begin
      v = station[47 - 8*idx -: 8];
    end else begin
      case (idx)
        32'(OFS_TCFG) + 3: v = 8'h63;
        32'(OFS_MED):      v = 8'h90;
        32'(OFS_PCTL) + 1: v = 8'h20;
        32'(OFS_PSTS):     v = 8'h25;
        32'(OFS_PSTS) + 1: v = 8'h20;
        default:           v = 8'h00;
      endcase
    end
    return v;
  endfunction

  function automatic logic [31:0] crc_step(input logic [31:0] crc_in,
                                           input logic [7:0] data);
    logic [31:0] c;
    c = crc_in ^ {24'h0, data};
    for (int b = 0; b < 8; b++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/nic_reg_store.sv
module nic_reg_store
  import nic_ctl_pkg::*;
#(
  parameter int          SPAN    = 129,
  parameter int          LANES   = 4,
  parameter int          SLOTS   = 4,
  parameter logic [47:0] STATION = 48'h021A2B3C4D5E
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    soft_rst,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES-1:0][8:0]   lane_addr,
  input  logic [LANES-1:0][7:0]   lane_wd,
  input  logic [SLOTS-1:0]        kick,
  output logic [LANES-1:0][7:0]   lane_rd,
  output logic [15:0]             mask,
  output logic [SLOTS-1:0][31:0]  slot_addr
);

  localparam int IW = $clog2(SPAN);

  logic [7:0] mem   [SPAN];
  logic [7:0] mem_n [SPAN];

  always_comb begin
    for (int i = 0; i < SPAN; i++) begin
      mem_n[i] = mem[i];
      for (int k = 0; k < LANES; k++) begin
        if (lane_we[k] && (lane_addr[k] == 9'(i))) begin
          mem_n[i] = lane_wd[k];
        end
      end
    end
    mem_n[32'(OFS_PCTL) + 1][PCTL_HI_CLR] = 1'b0;
    for (int n = 0; n < SLOTS; n++) begin
      if (kick[n]) begin
        mem_n[32'(OFS_TSD0) + 4*n + 1] = mem_n[32'(OFS_TSD0) + 4*n + 1] | OWN_DONE_HI;
      end
    end
    mem_n[32'(OFS_CMD)]     = 8'h00;
    mem_n[32'(OFS_ISR)]     = 8'h00;
    mem_n[32'(OFS_ISR) + 1] = 8'h00;
    if (soft_rst) begin
      for (int i = 0; i < SPAN; i++) begin
        mem_n[i] = reset_byte(i, STATION);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SPAN; i++) begin
        mem[i] <= reset_byte(i, STATION);
      end
    end else begin
      for (int i = 0; i < SPAN; i++) begin
        mem[i] <= mem_n[i];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      lane_rd[k] = (lane_addr[k] < 9'(SPAN)) ? mem[lane_addr[k][IW-1:0]] : 8'h00;
    end
  end

  assign mask = {mem[32'(OFS_IMR) + 1], mem[32'(OFS_IMR)]};

  generate
    for (genvar n = 0; n < SLOTS; n++) begin : g_slot
      assign slot_addr[n] = {mem[32'(OFS_TSA0) + 4*n + 3], mem[32'(OFS_TSA0) + 4*n + 2],
                             mem[32'(OFS_TSA0) + 4*n + 1], mem[32'(OFS_TSA0) + 4*n]};
    end
  endgenerate

endmodule

// File: rtl/nic_cmd_intr.sv
module nic_cmd_intr
  import nic_ctl_pkg::*;
#(
  parameter int IRQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_wd,
  input  logic             isr_clr,
  input  logic [IRQ_W-1:0] evt_set,
  input  logic             tx_fired,
  input  logic [IRQ_W-1:0] mask,
  output logic             soft_rst,
  output logic [7:0]       cmd_q,
  output logic [IRQ_W-1:0] isr_q,
  output logic             cmd_bad,
  output logic             irq
);

  logic [7:0]       cmd_n;
  logic [IRQ_W-1:0] isr_n;
  logic             bad_n;

  assign soft_rst = cmd_wr && cmd_wd[CMD_RST_BIT];

  always_comb begin
    cmd_n = soft_rst ? CMD_RESET_VAL : cmd_q;
    if (cmd_wr) begin
      cmd_n = cmd_n | (cmd_wd & CMD_SET_MASK);
    end
    bad_n = cmd_wr && ((cmd_wd & ~CMD_OK_MASK) != 8'h00);
    if (soft_rst) begin
      isr_n = '0;
    end else begin
      isr_n = (isr_clr ? '0 : isr_q) | evt_set;
      if (tx_fired) begin
        isr_n = isr_n | IRQ_W'(ISR_TX_DONE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= CMD_RESET_VAL;
      isr_q   <= '0;
      cmd_bad <= 1'b0;
    end else begin
      cmd_q   <= cmd_n;
      isr_q   <= isr_n;
      cmd_bad <= bad_n;
    end
  end

  assign irq = |(mask & isr_q);

endmodule

// File: rtl/nic_tx_kick.sv
module nic_tx_kick
  import nic_ctl_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int LEN_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_en,
  input  logic                    bus_we,
  input  logic [7:0]              bus_addr,
  input  logic [LEN_W-1:0]        wlen,
  input  logic [SLOTS-1:0][31:0]  slot_addr,
  output logic [SLOTS-1:0]        kick,
  output logic                    tx_go,
  output logic [$clog2(SLOTS)-1:0] tx_slot,
  output logic [31:0]             tx_addr,
  output logic [LEN_W-1:0]        tx_len
);

  localparam int SW = $clog2(SLOTS);

  logic          fire;
  logic [SW-1:0] slot_sel;

  assign slot_sel = bus_addr[2 +: SW];
  assign fire = bus_en && bus_we && (bus_addr[1:0] == 2'b00) &&
                (bus_addr >= OFS_TSD0) && (bus_addr < OFS_TSD0 + 8'(4*SLOTS));

  generate
    for (genvar n = 0; n < SLOTS; n++) begin : g_kick
      assign kick[n] = fire && (slot_sel == SW'(n));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_go <= 1'b0;
    end else begin
      tx_go <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_slot <= '0;
      tx_addr <= '0;
      tx_len  <= '0;
    end else if (fire) begin
      tx_slot <= slot_sel;
      tx_addr <= slot_addr[slot_sel];
      tx_len  <= wlen;
    end
  end

endmodule

// File: rtl/nic_crc_append.sv
module nic_crc_append
  import nic_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fr_valid,
  output logic       fr_ready,
  input  logic [7:0] fr_data,
  input  logic       fr_last,
  output logic       wire_valid,
  output logic [7:0] wire_data,
  output logic       wire_last
);

  crc_st_t     st, st_n;
  logic [1:0]  cnt, cnt_n;
  logic [31:0] crc, crc_n;
  logic        v_n, l_n;
  logic [7:0]  d_n;
  logic [31:0] fin;

  assign fr_ready = (st == ST_PASS);
  assign fin = ~crc;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    crc_n = crc;
    v_n   = 1'b0;
    l_n   = 1'b0;
    d_n   = wire_data;
    if (st == ST_PASS) begin
      if (fr_valid) begin
        v_n   = 1'b1;
        d_n   = fr_data;
        crc_n = crc_step(crc, fr_data);
        if (fr_last) begin
          st_n  = ST_TRAIL;
          cnt_n = 2'd0;
        end
      end
    end else begin
      v_n   = 1'b1;
      d_n   = fin[8*cnt +: 8];
      l_n   = (cnt == 2'd3);
      cnt_n = cnt + 2'd1;
      if (cnt == 2'd3) begin
        st_n  = ST_PASS;
        crc_n = '1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_PASS;
      cnt        <= 2'd0;
      crc        <= '1;
      wire_valid <= 1'b0;
      wire_last  <= 1'b0;
      wire_data  <= 8'h00;
    end else begin
      st         <= st_n;
      cnt        <= cnt_n;
      crc        <= crc_n;
      wire_valid <= v_n;
      wire_last  <= l_n;
      wire_data  <= d_n;
    end
  end

endmodule

// File: rtl/nic_ctl_regs.sv
module nic_ctl_regs
  import nic_ctl_pkg::*;
#(
  parameter int          SPAN    = 129,
  parameter int          DATA_W  = 32,
  parameter int          SLOTS   = 4,
  parameter int          LEN_W   = 12,
  parameter int          IRQ_W   = 16,
  parameter logic [47:0] STATION = 48'h021A2B3C4D5E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [IRQ_W-1:0]  evt_set,
  output logic              intr_req,
  output logic              rx_enabled,
  output logic              tx_enabled,
  output logic              cmd_bad,
  output logic              tx_go,
  output logic [1:0]        tx_slot,
  output logic [31:0]       tx_addr,
  output logic [LEN_W-1:0]  tx_len,
  input  logic              fr_valid,
  output logic              fr_ready,
  input  logic [7:0]        fr_data,
  input  logic              fr_last,
  output logic              wire_valid,
  output logic [7:0]        wire_data,
  output logic              wire_last
);

  localparam int LANES = DATA_W / 8;

  logic [1:0] rst_pipe;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_ns = rst_pipe[1];

  logic [LANES-1:0]        lane_act, lane_we;
  logic [LANES-1:0][8:0]   lane_addr;
  logic [LANES-1:0][7:0]   lane_wd, lane_rd, rd_n;
  logic [3:0]              nbytes;
  logic                    cmd_wr, soft_rst, isr_clr;
  logic [7:0]              cmd_wd, cmd_q;
  logic [IRQ_W-1:0]        isr_q;
  logic [15:0]             mask;
  logic [SLOTS-1:0]        kick;
  logic [SLOTS-1:0][31:0]  slot_addr;

  always_comb begin
    case (bus_size)
      2'd0:    nbytes = 4'd1;
      2'd1:    nbytes = 4'd2;
      default: nbytes = 4'(LANES);
    endcase
  end

  always_comb begin
    cmd_wr = 1'b0;
    cmd_wd = 8'h00;
    for (int k = 0; k < LANES; k++) begin
      lane_addr[k] = {1'b0, bus_addr} + 9'(k);
      lane_wd[k]   = bus_wdata[8*k +: 8];
      lane_act[k]  = bus_en && (4'(k) < nbytes);
      lane_we[k]   = lane_act[k] && bus_we && (lane_addr[k] < 9'(SPAN));
      if (lane_we[k] && (lane_addr[k] == {1'b0, OFS_CMD})) begin
        cmd_wr = 1'b1;
        cmd_wd = lane_wd[k];
      end
    end
  end

  assign isr_clr = bus_en && !bus_we && (bus_addr == OFS_ISR);

  nic_reg_store #(
    .SPAN(SPAN), .LANES(LANES), .SLOTS(SLOTS), .STATION(STATION)
  ) u_store (
    .clk(clk), .rst_n(rst_ns), .soft_rst(soft_rst),
    .lane_we(lane_we), .lane_addr(lane_addr), .lane_wd(lane_wd),
    .kick(kick), .lane_rd(lane_rd), .mask(mask), .slot_addr(slot_addr)
  );

  nic_cmd_intr #(.IRQ_W(IRQ_W)) u_cmd (
    .clk(clk), .rst_n(rst_ns), .cmd_wr(cmd_wr), .cmd_wd(cmd_wd),
    .isr_clr(isr_clr), .evt_set(evt_set), .tx_fired(|kick),
    .mask(IRQ_W'(mask)), .soft_rst(soft_rst), .cmd_q(cmd_q),
    .isr_q(isr_q), .cmd_bad(cmd_bad), .irq(intr_req)
  );

  nic_tx_kick #(.SLOTS(SLOTS), .LEN_W(LEN_W)) u_kick (
    .clk(clk), .rst_n(rst_ns), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .wlen(bus_wdata[LEN_W-1:0]), .slot_addr(slot_addr),
    .kick(kick), .tx_go(tx_go), .tx_slot(tx_slot), .tx_addr(tx_addr),
    .tx_len(tx_len)
  );

  nic_crc_append u_crc (
    .clk(clk), .rst_n(rst_ns), .fr_valid(fr_valid), .fr_ready(fr_ready),
    .fr_data(fr_data), .fr_last(fr_last), .wire_valid(wire_valid),
    .wire_data(wire_data), .wire_last(wire_last)
  );

  assign rx_enabled = cmd_q[3];
  assign tx_enabled = cmd_q[2];

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      if (!lane_act[k]) begin
        rd_n[k] = 8'h00;
      end else if (lane_addr[k] == {1'b0, OFS_CMD}) begin
        rd_n[k] = cmd_q;
      end else if (lane_addr[k] == {1'b0, OFS_ISR}) begin
        rd_n[k] = isr_q[7:0];
      end else if (lane_addr[k] == {1'b0, OFS_ISR} + 9'd1) begin
        rd_n[k] = isr_q[15:8];
      end else begin
        rd_n[k] = lane_rd[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      bus_rdata <= '0;
    end else if (bus_en && !bus_we) begin
      bus_rdata <= rd_n;
    end
  end

endmodule

// File: rtl/nic_ctl_regs_chk.sv
module nic_ctl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_en,
  input logic        bus_we,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [15:0] evt_set,
  input logic        intr_req,
  input logic        rx_enabled,
  input logic        tx_go,
  input logic [11:0] tx_len,
  input logic        fr_valid,
  input logic        fr_ready,
  input logic        fr_last,
  input logic        wire_valid,
  input logic        wire_last
);

  logic [19:0] unused_bits;
  assign unused_bits = {bus_wdata[31:12], 0};

  assert_isr_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == 8'h3E && evt_set == 16'h0) |=> !intr_req);

  assert_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr[7:4] == 4'h1 && bus_addr[1:0] == 2'b00)
      |=> (tx_go && tx_len == $past(bus_wdata[11:0])));

  assert_go_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |-> $past(bus_en && bus_we));

  assert_enable_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_enabled) |-> $past(bus_en && bus_we));

  assert_trailer_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && fr_ready && fr_last) |=> !fr_ready);

  assert_last_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wire_last |-> wire_valid);

endmodule

bind nic_ctl_regs nic_ctl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_ns), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .evt_set(evt_set),
  .intr_req(intr_req), .rx_enabled(rx_enabled), .tx_go(tx_go),
  .tx_len(tx_len), .fr_valid(fr_valid), .fr_ready(fr_ready),
  .fr_last(fr_last), .wire_valid(wire_valid), .wire_last(wire_last)
);

// File: tb/tb_nic_ctl_regs.sv
module tb_nic_ctl_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [1:0]  bus_size = 2'd0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [15:0] evt_set = 16'h0;
  logic        intr_req, rx_enabled, tx_enabled, cmd_bad, tx_go;
  logic [1:0]  tx_slot;
  logic [31:0] tx_addr;
  logic [11:0] tx_len;
  logic        fr_valid = 1'b0, fr_ready, fr_last = 1'b0;
  logic [7:0]  fr_data = 8'h00;
  logic        wire_valid, wire_last;
  logic [7:0]  wire_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nic_ctl_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .evt_set(evt_set), .intr_req(intr_req),
    .rx_enabled(rx_enabled), .tx_enabled(tx_enabled), .cmd_bad(cmd_bad),
    .tx_go(tx_go), .tx_slot(tx_slot), .tx_addr(tx_addr), .tx_len(tx_len),
    .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_data(fr_data),
    .fr_last(fr_last), .wire_valid(wire_valid), .wire_data(wire_data),
    .wire_last(wire_last)
  );

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [1:0]  sz;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 2'd2, 32'h0,        32'h3C2B1A02, 8'd1},  // R1 station low
    '{1'b0, 8'h04, 2'd1, 32'h0,        32'h00005E4D, 8'd1},  // R1 station high
    '{1'b0, 8'h40, 2'd2, 32'h0,        32'h63000000, 8'd1},  // R1 tx config
    '{1'b0, 8'h58, 2'd0, 32'h0,        32'h00000090, 8'd1},  // R1 media
    '{1'b0, 8'h62, 2'd1, 32'h0,        32'h00002000, 8'd1},  // R1 phy control
    '{1'b0, 8'h64, 2'd1, 32'h0,        32'h00002025, 8'd1},  // R1 phy status
    '{1'b0, 8'h37, 2'd0, 32'h0,        32'h00000001, 8'd1},  // R1 command
    '{1'b1, 8'h48, 2'd2, 32'hA5B6C7D8, 32'h0,        8'd10}, // R10
    '{1'b0, 8'h48, 2'd2, 32'h0,        32'hA5B6C7D8, 8'd10}, // R10
    '{1'b1, 8'h49, 2'd0, 32'h00000011, 32'h0,        8'd10}, // R10
    '{1'b0, 8'h48, 2'd2, 32'h0,        32'hA5B611D8, 8'd10}, // R10
    '{1'b1, 8'h4A, 2'd1, 32'h00001234, 32'h0,        8'd10}, // R10
    '{1'b0, 8'h48, 2'd2, 32'h0,        32'h123411D8, 8'd10}, // R10
    '{1'b1, 8'h62, 2'd1, 32'h0000FFFF, 32'h0,        8'd9},  // R9
    '{1'b0, 8'h62, 2'd1, 32'h0,        32'h0000FDFF, 8'd9},  // R9
    '{1'b1, 8'h63, 2'd0, 32'h00000002, 32'h0,        8'd9},  // R9
    '{1'b0, 8'h62, 2'd1, 32'h0,        32'h000000FF, 8'd9},  // R9
    '{1'b1, 8'h90, 2'd2, 32'hDEADBEEF, 32'h0,        8'd11}, // R11
    '{1'b0, 8'h90, 2'd2, 32'h0,        32'h00000000, 8'd11}, // R11
    '{1'b1, 8'h80, 2'd2, 32'h7766555A, 32'h0,        8'd11}, // R11
    '{1'b0, 8'h80, 2'd2, 32'h0,        32'h0000005A, 8'd11}, // R11
    '{1'b1, 8'h3E, 2'd1, 32'h0000FFFF, 32'h0,        8'd13}, // R13
    '{1'b0, 8'h3E, 2'd1, 32'h0,        32'h00000000, 8'd13}, // R13
    '{1'b1, 8'h37, 2'd0, 32'h0000000C, 32'h0,        8'd4}   // R4
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [7:0] a, input logic [1:0] sz,
                     input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  logic [7:0] got [32];
  logic       got_last [32];
  int         ng = 0;

  always @(negedge clk) begin
    if (wire_valid && ng < 32) begin
      got[ng] = wire_data;
      got_last[ng] = wire_last;
      ng++;
    end
  end

  logic [7:0] frm [16];

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'h0, frm[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic send_frame(input int n, input logic [31:0] exp_crc);
    logic [7:0] e;
    ng = 0;
    for (int i = 0; i < n; i++) begin
      while (!fr_ready) @(negedge clk);
      fr_valid = 1'b1; fr_data = frm[i]; fr_last = (i == n - 1);
      @(negedge clk);
      fr_valid = 1'b0; fr_last = 1'b0;
    end
    chk("R12 ready low in trailer", {31'h0, fr_ready}, 32'h0);
    repeat (6) @(negedge clk);
    chk("R12 byte count", ng, n + 4);
    for (int i = 0; i < n + 4 && i < 32; i++) begin
      e = (i < n) ? frm[i] : exp_crc[8*(i-n) +: 8];
      chk("R12 byte", {24'h0, got[i]}, {24'h0, e});
      chk("R12 last flag", {31'h0, got_last[i]}, {31'h0, (i == n + 3)});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 intr_req in reset", {31'h0, intr_req}, 32'h0);
    chk("R1 tx_go in reset", {31'h0, tx_go}, 32'h0);
    chk("R1 wire_valid in reset", {31'h0, wire_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      acc(VEC[v].we, VEC[v].addr, VEC[v].sz, VEC[v].wd);
      if (!VEC[v].we) begin
        checks++;
        if (bus_rdata !== VEC[v].exp) begin
          errors++;
          $display("FAIL R%0d vector %0d actual=%h expected=%h", VEC[v].req, v,
                   bus_rdata, VEC[v].exp);
        end
      end
    end

    // R4 enables
    acc(1'b0, 8'h37, 2'd0, 0);
    chk("R4 command readback", bus_rdata, 32'h0000000D);
    chk("R4 rx_enabled", {31'h0, rx_enabled}, 32'h1);
    chk("R4 tx_enabled", {31'h0, tx_enabled}, 32'h1);
    acc(1'b1, 8'h37, 2'd0, 32'h0);
    chk("R4 sticky enable", {31'h0, rx_enabled}, 32'h1);

    // R6 invalid bits
    acc(1'b1, 8'h37, 2'd0, 32'h03);
    chk("R6 cmd_bad on bits 1:0", {31'h0, cmd_bad}, 32'h1);
    acc(1'b1, 8'h37, 2'd0, 32'h08);
    chk("R6 cmd_bad on valid bit", {31'h0, cmd_bad}, 32'h0);

    // R3 / R7 / R8 launch
    acc(1'b1, 8'h3C, 2'd1, 32'h0004);
    chk("R3 no cause yet", {31'h0, intr_req}, 32'h0);
    acc(1'b1, 8'h24, 2'd2, 32'h00012340);
    acc(1'b1, 8'h14, 2'd2, 32'h00000234);
    chk("R7 tx_go", {31'h0, tx_go}, 32'h1);
    chk("R7 tx_slot", {30'h0, tx_slot}, 32'h1);
    chk("R7 tx_addr", tx_addr, 32'h00012340);
    chk("R7 tx_len", {20'h0, tx_len}, 32'h234);
    chk("R3 intr on tx done", {31'h0, intr_req}, 32'h1);
    @(negedge clk);
    chk("R7 tx_go one cycle", {31'h0, tx_go}, 32'h0);
    acc(1'b0, 8'h14, 2'd2, 0);
    chk("R8 owned status word", bus_rdata, 32'h0000A234);
    acc(1'b0, 8'h3E, 2'd1, 0);
    chk("R8 tx done cause", bus_rdata, 32'h0004);
    chk("R3 intr cleared", {31'h0, intr_req}, 32'h0);
    acc(1'b0, 8'h3E, 2'd1, 0);
    chk("R2 status cleared by read", bus_rdata, 32'h0);

    // R3 masked cause
    @(negedge clk); evt_set = 16'h0001;
    @(negedge clk); evt_set = 16'h0000;
    chk("R3 masked cause silent", {31'h0, intr_req}, 32'h0);
    acc(1'b1, 8'h3C, 2'd1, 32'h0001);
    chk("R3 unmasked cause", {31'h0, intr_req}, 32'h1);

    // R2 cause arriving during clearing read
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = 8'h3E; bus_size = 2'd1; evt_set = 16'h0100;
    @(negedge clk);
    bus_en = 1'b0; evt_set = 16'h0;
    chk("R2 read returns old status", bus_rdata, 32'h0001);
    acc(1'b0, 8'h3E, 2'd1, 0);
    chk("R2 concurrent cause kept", bus_rdata, 32'h0100);

    // R5 full reset
    acc(1'b1, 8'h48, 2'd2, 32'hCAFEF00D);
    acc(1'b1, 8'h37, 2'd0, 32'h10);
    chk("R5 rx_enabled cleared", {31'h0, rx_enabled}, 32'h0);
    acc(1'b0, 8'h37, 2'd0, 0);
    chk("R5 command value", bus_rdata, 32'h01);
    acc(1'b0, 8'h48, 2'd2, 0);
    chk("R5 scratch cleared", bus_rdata, 32'h0);
    acc(1'b0, 8'h62, 2'd1, 0);
    chk("R5 phy control", bus_rdata, 32'h2000);
    acc(1'b0, 8'h3C, 2'd1, 0);
    chk("R5 mask cleared", bus_rdata, 32'h0);

    // R12 CRC trailer
    for (int i = 0; i < 9; i++) frm[i] = 8'h31 + 8'(i);
    chk("R12 reference check value", ref_crc(9), 32'hCBF43926);
    send_frame(9, 32'hCBF43926);
    frm[0] = 8'hFF; frm[1] = 8'h00; frm[2] = 8'hA5;
    send_frame(3, ref_crc(3));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule